// File: doc/BRIEF.md
# SCSI DMA Byte Packer

This block moves data between an 8-bit SCSI bus controller's DMA byte handshake and a 32-bit memory-side bus master. On a receive it gathers incoming bytes, first byte in the most significant lane, and issues one 32-bit memory write for every four bytes. On a send it fetches 32-bit words from memory and hands them out one byte at a time, most significant byte first. A byte residual counter, loaded from the transfer count when DMA is enabled, counts down as bytes move and tells software how much remains.

Software drives the block through a small 16-bit register port: a control/status word, address and transfer count split into high and low halves, residual halves, two read-only pack holding registers and an interrupt vector register. When a receive is stopped early by clearing DMA enable, the bytes that had not yet formed a full word stay in the pack holding registers. Their number is reported in the status word, so software can copy them by hand. The memory side is a plain request/grant port, and the SCSI phase logic is outside this block.

Top module: `scsi_pack_dma`

## Requirements
- R1: After reset, and after software writes zero to the control/status word, it reads 0x1400: bit 12 is a fixed identity bit and bit 10 (packer empty) is set. The other status bits are: 15 DMA active, 14 conflict, 13 bus error, 9 bus-controller interrupt pending, 8 DMA interrupt pending and 7:6 leftover count. The writable control bits are: 5 pack enable, 4 DMA enable, 3 direction (1 = send), 2 interrupt enable, 1 FIFO reset (active low) and 0 SCSI select.
- R2: The interrupt vector register (index 7) reads 0x3D in bits 15:8 and the written vector number in bits 7:0.
- R3: On a receive, every four accepted bytes form one 32-bit memory write, with the first byte in bits 31:24. A write is only requested when four bytes are held. The address register advances by 4 after each completed write.
- R4: When DMA enable goes from 0 to 1, the residual is loaded with the transfer count. It drops by one for each byte moved. When it reaches zero, status bit 8 is set and no further byte is accepted.
- R5: When DMA enable is cleared, byte strobes get no acknowledge and the residual and pack contents stay frozen. Bits 7:6 give the leftover count (01, 10 or 11 bytes). The first leftover byte is in pack-high bits 15:8, the second in pack-high bits 7:0 and the third in pack-low bits 15:8.
- R6: On a send, a 32-bit memory read is requested when the unpack buffer is empty and the residual is non-zero. Its bytes are delivered most significant first, one per acknowledged strobe, and the address advances by 4 per read.
- R7: A memory grant with the error input set sets status bit 13 and stops the transfer. The bit stays set until FIFO reset is driven low.
- R8: Writing an address or count half while DMA is active (enabled, residual non-zero, no bus error) sets status bit 14. The bit stays set until FIFO reset is driven low.
- R9: While control bit 1 is 0, the packer, the leftover count, the residual and the sticky flags are held clear, and status bit 10 reads 1.
- R10: The interrupt output is registered. It is high when interrupt enable is set and any of status bits 9, 8, 13 or 14 is set.
- R11: Register indices are: 0/1 address high/low, 2/3 count high/low, 4 control/status, 5/6 pack high/low, 8/9 residual high/low. Read data appears one cycle after the index is presented. Control bit 0 drives the select output.
- R12: Bytes move only while both DMA enable and pack enable are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one cycle after index |
| scsi_req | input | 1 | One-cycle byte strobe from the bus controller |
| scsi_din | input | 8 | Received byte |
| scsi_ack | output | 1 | Byte taken/delivered, one cycle after strobe |
| scsi_dout | output | 8 | Byte to send, valid with scsi_ack |
| scsi_sel | output | 1 | Select line to the bus controller |
| sbc_irq | input | 1 | Bus controller interrupt request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant, completes the request |
| mem_err | input | 1 | Bus error, qualified by grant |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default vector tag of 0x3D, so identity and vector reads can be compared with fixed values. The 32-bit word and the four-lane packer are exercised as well. Transfer counts of 10, 20, 6 and 8 bytes are chosen so that runs end with two and three leftover bytes, a send ends partway through a word, and a stall while a word write is pending forces the byte strobes to be retried.

// File: rtl/scsi_pack_pkg.sv
package scsi_pack_pkg;
  localparam int WORD_W = 32;
  localparam int BYTES  = WORD_W / 8;
  localparam int CNT_W  = $clog2(BYTES) + 1;
  localparam int RA_W   = 4;
  localparam int RD_W   = 16;

  localparam logic [RA_W-1:0] RG_ADDR_HI = 4'd0;
  localparam logic [RA_W-1:0] RG_ADDR_LO = 4'd1;
  localparam logic [RA_W-1:0] RG_CNT_HI  = 4'd2;
  localparam logic [RA_W-1:0] RG_CNT_LO  = 4'd3;
  localparam logic [RA_W-1:0] RG_CSR     = 4'd4;
  localparam logic [RA_W-1:0] RG_PACK_HI = 4'd5;
  localparam logic [RA_W-1:0] RG_PACK_LO = 4'd6;
  localparam logic [RA_W-1:0] RG_VEC     = 4'd7;
  localparam logic [RA_W-1:0] RG_RES_HI  = 4'd8;
  localparam logic [RA_W-1:0] RG_RES_LO  = 4'd9;

  typedef struct packed {
    logic pack;
    logic en;
    logic send;
    logic ien;
    logic fifo_n;
    logic sel;
  } ctl_t;
endpackage

// File: rtl/scsi_pack_lane.sv
module scsi_pack_lane
  import scsi_pack_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              run,
  input  logic              send,
  input  logic              resid_nz,
  input  logic              byte_req,
  input  logic [7:0]        byte_in,
  output logic              byte_ack,
  output logic [7:0]        byte_out,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_err,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              moved,
  output logic              word_done,
  output logic              err_hit,
  output logic [WORD_W-1:0] hold,
  output logic [CNT_W-1:0]  fill
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTES);

  logic [WORD_W-1:0] hold_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              mreq_q, mwe_q, ack_q;
  logic [7:0]        dout_q;
  logic              take, done, want;

  assign done = mreq_q && mem_gnt;
  assign take = run && byte_req && resid_nz && !mreq_q &&
                (send ? (cnt_q != '0) : (cnt_q != FULL));
  assign want = send ? (cnt_q == '0 && resid_nz) : (cnt_q == FULL);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hold_q <= '0;
      cnt_q  <= '0;
      mreq_q <= 1'b0;
      mwe_q  <= 1'b0;
      ack_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      ack_q <= take;
      if (done) begin
        mreq_q <= 1'b0;
        if (!mem_err) begin
          if (mwe_q) begin
            hold_q <= '0;
            cnt_q  <= '0;
          end else begin
            hold_q <= mem_rdata;
            cnt_q  <= FULL;
          end
        end
      end else if (!run) begin
        mreq_q <= 1'b0;
      end else if (!mreq_q && want) begin
        mreq_q <= 1'b1;
        mwe_q  <= !send;
      end
      if (take) begin
        if (send) begin
          dout_q <= hold_q[WORD_W-1 -: 8];
          hold_q <= {hold_q[WORD_W-9:0], 8'h00};
          cnt_q  <= cnt_q - 1'b1;
        end else begin
          for (int i = 0; i < BYTES; i++) begin
            if (cnt_q == CNT_W'(i)) hold_q[WORD_W-1-8*i -: 8] <= byte_in;
          end
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign byte_ack  = ack_q;
  assign byte_out  = dout_q;
  assign mem_req   = mreq_q;
  assign mem_we    = mwe_q;
  assign mem_wdata = hold_q;
  assign moved     = take;
  assign word_done = done && !mem_err;
  assign err_hit   = done && mem_err;
  assign hold      = hold_q;
  assign fill      = cnt_q;
endmodule

// File: rtl/scsi_pack_regs.sv
module scsi_pack_regs
  import scsi_pack_pkg::*;
#(
  parameter logic [7:0] VEC_TAG = 8'h3D
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RA_W-1:0]   addr,
  input  logic [RD_W-1:0]   wdata,
  output logic [RD_W-1:0]   rdata,
  input  logic              sbc_irq,
  input  logic              moved,
  input  logic              word_done,
  input  logic              err_hit,
  input  logic [WORD_W-1:0] hold,
  input  logic [CNT_W-1:0]  fill,
  output ctl_t              ctl,
  output logic              clr,
  output logic              run,
  output logic              resid_nz,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] resid,
  output logic              buserr,
  output logic              irq
);
  ctl_t              ctl_q;
  logic [WORD_W-1:0] addr_q, cnt_q, res_q;
  logic [7:0]        vec_q;
  logic              err_q, cfl_q, dint_q, irq_q;
  logic              active, empty;
  logic [1:0]        left;
  logic [RD_W-1:0]   csr_v, rd_q;

  assign clr      = !ctl_q.fifo_n;
  assign resid_nz = (res_q != '0);
  assign active   = ctl_q.en && resid_nz && !err_q;
  assign run      = ctl_q.en && ctl_q.pack && !err_q && ctl_q.fifo_n;
  assign empty    = (fill == '0);
  assign left     = (!ctl_q.send && fill < CNT_W'(BYTES)) ? fill[1:0] : 2'b00;
  assign csr_v    = {active, cfl_q, err_q, 1'b1, 1'b0, empty, sbc_irq, dint_q,
                     left, ctl_q.pack, ctl_q.en, ctl_q.send, ctl_q.ien,
                     ctl_q.fifo_n, ctl_q.sel};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      res_q  <= '0;
      vec_q  <= '0;
      err_q  <= 1'b0;
      cfl_q  <= 1'b0;
      dint_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (word_done) addr_q <= addr_q + WORD_W'(BYTES);
      if (moved) begin
        res_q <= res_q - 1'b1;
        if (res_q == WORD_W'(1)) dint_q <= 1'b1;
      end
      if (err_hit) err_q <= 1'b1;
      if (we) begin
        if (addr <= RG_CNT_LO && active) cfl_q <= 1'b1;
        case (addr)
          RG_ADDR_HI: addr_q[31:16] <= wdata;
          RG_ADDR_LO: addr_q[15:0]  <= wdata;
          RG_CNT_HI:  cnt_q[31:16]  <= wdata;
          RG_CNT_LO:  cnt_q[15:0]   <= wdata;
          RG_CSR: begin
            ctl_q <= wdata[5:0];
            if (wdata[4] && !ctl_q.en) res_q <= cnt_q;
          end
          RG_VEC:     vec_q         <= wdata[7:0];
          RG_RES_HI:  res_q[31:16]  <= wdata;
          RG_RES_LO:  res_q[15:0]   <= wdata;
          default: ;
        endcase
      end
      if (clr) begin
        res_q  <= '0;
        err_q  <= 1'b0;
        cfl_q  <= 1'b0;
        dint_q <= 1'b0;
      end
      irq_q <= ctl_q.ien && (sbc_irq || dint_q || err_q || cfl_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      case (addr)
        RG_ADDR_HI: rd_q <= addr_q[31:16];
        RG_ADDR_LO: rd_q <= addr_q[15:0];
        RG_CNT_HI:  rd_q <= cnt_q[31:16];
        RG_CNT_LO:  rd_q <= cnt_q[15:0];
        RG_CSR:     rd_q <= csr_v;
        RG_PACK_HI: rd_q <= hold[31:16];
        RG_PACK_LO: rd_q <= hold[15:0];
        RG_VEC:     rd_q <= {VEC_TAG, vec_q};
        RG_RES_HI:  rd_q <= res_q[31:16];
        RG_RES_LO:  rd_q <= res_q[15:0];
        default:    rd_q <= '0;
      endcase
    end
  end

  assign rdata    = rd_q;
  assign ctl      = ctl_q;
  assign mem_addr = addr_q;
  assign resid    = res_q;
  assign buserr   = err_q;
  assign irq      = irq_q;
endmodule

// File: rtl/scsi_pack_dma.sv
module scsi_pack_dma
  import scsi_pack_pkg::*;
#(
  parameter logic [7:0] VEC_TAG = 8'h3D
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        scsi_req,
  input  logic [7:0]  scsi_din,
  output logic        scsi_ack,
  output logic [7:0]  scsi_dout,
  output logic        scsi_sel,
  input  logic        sbc_irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  output logic        irq
);
  ctl_t              ctl_w;
  logic              clr_w, run_w, resid_nz_w, buserr_w;
  logic              moved_w, word_done_w, err_hit_w;
  logic [WORD_W-1:0] hold_w, resid_w;
  logic [CNT_W-1:0]  fill_w;
  logic              fifo_n_w;

  scsi_pack_regs #(.VEC_TAG(VEC_TAG)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .sbc_irq(sbc_irq), .moved(moved_w),
    .word_done(word_done_w), .err_hit(err_hit_w), .hold(hold_w),
    .fill(fill_w), .ctl(ctl_w), .clr(clr_w), .run(run_w),
    .resid_nz(resid_nz_w), .mem_addr(mem_addr), .resid(resid_w),
    .buserr(buserr_w), .irq(irq)
  );

  scsi_pack_lane u_lane (
    .clk(clk), .rst(rst), .clr(clr_w), .run(run_w), .send(ctl_w.send),
    .resid_nz(resid_nz_w), .byte_req(scsi_req), .byte_in(scsi_din),
    .byte_ack(scsi_ack), .byte_out(scsi_dout), .mem_req(mem_req),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .moved(moved_w),
    .word_done(word_done_w), .err_hit(err_hit_w), .hold(hold_w),
    .fill(fill_w)
  );

  assign scsi_sel = ctl_w.sel;
  assign fifo_n_w = ctl_w.fifo_n;
endmodule

// File: rtl/scsi_pack_chk.sv
module scsi_pack_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_we,
  input logic        scsi_ack,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_gnt,
  input logic [31:0] mem_addr,
  input logic [31:0] resid,
  input logic [2:0]  fill,
  input logic        run,
  input logic        fifo_n,
  input logic        buserr
);
  p_hold_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !fifo_n |=> (resid == 32'd0 && fill == 3'd0));

  p_resid_step_r4: assert property (@(posedge clk) disable iff (rst)
    (scsi_ack && !$past(reg_we)) |-> resid == $past(resid) - 32'd1);

  p_word_full_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> fill == 3'd4);

  p_ack_run_r5: assert property (@(posedge clk) disable iff (rst)
    scsi_ack |-> $past(run));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(buserr) && $past(fifo_n)) |-> buserr);

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt && !reg_we) |=> $stable(mem_addr));
endmodule

bind scsi_pack_dma scsi_pack_chk u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .scsi_ack(scsi_ack),
  .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .resid(resid_w), .fill(fill_w), .run(run_w),
  .fifo_n(fifo_n_w), .buserr(buserr_w)
);

// File: tb/scsi_pack_dma_bench.sv
`timescale 1ns/1ps
module scsi_pack_dma_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        scsi_req = 1'b0;
  logic [7:0]  scsi_din = 8'd0;
  logic        scsi_ack;
  logic [7:0]  scsi_dout;
  logic        scsi_sel;
  logic        sbc_irq = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0;
  logic        mem_err = 1'b0;
  logic [31:0] mem_rdata = 32'd0;
  logic        irq;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;
  bit err_arm = 0;
  logic [63:0] exp_q[$];

  always #5 clk = ~clk;

  scsi_pack_dma u_scsi_pack_dma (.*);

  function automatic logic [31:0] mword(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0] + 16'h0F1E};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // memory responder and write monitor (scoreboard consumer)
  initial forever begin
    @(negedge clk);
    if (mem_req && !mem_gnt) begin
      mem_gnt = 1'b1;
      mem_err = err_arm;
      if (!mem_we) mem_rdata = mword(mem_addr);
      else if (!err_arm) begin
        if (exp_q.size() == 0) chk("R3 unexpected write", mem_addr, 32'hFFFF_FFFF);
        else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk("R3 write address", mem_addr, e[63:32]);
          chk("R3 write data", mem_wdata, e[31:0]);
        end
      end
    end else begin
      mem_gnt = 1'b0;
      mem_err = 1'b0;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic byte_rx(input logic [7:0] b);
    bit ok = 0;
    for (int t = 0; t < 30 && !ok; t++) begin
      @(negedge clk);
      scsi_req = 1'b1; scsi_din = b;
      @(negedge clk);
      scsi_req = 1'b0;
      ok = scsi_ack;
    end
    if (!ok) chk("R3 byte never acknowledged", 32'd0, 32'd1);
  endtask

  task automatic byte_tx(input string tag, input logic [7:0] exp);
    bit ok = 0;
    for (int t = 0; t < 30 && !ok; t++) begin
      @(negedge clk);
      scsi_req = 1'b1;
      @(negedge clk);
      scsi_req = 1'b0;
      ok = scsi_ack;
    end
    if (!ok) chk({tag, " no ack"}, 32'd0, 32'd1);
    else chk(tag, {24'd0, scsi_dout}, {24'd0, exp});
  endtask

  task automatic byte_none(input string tag);
    @(negedge clk);
    scsi_req = 1'b1; scsi_din = 8'hEE;
    @(negedge clk);
    scsi_req = 1'b0;
    chk(tag, {31'd0, scsi_ack}, 32'd0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [7:0] b [0:19];
    for (int i = 0; i < 20; i++) b[i] = 8'h10 + 8'(i * 7);
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(4'd4, d); chk("R1 reset csr", {16'd0, d}, 32'h1400);
    chk("R11 select after reset", {31'd0, scsi_sel}, 32'd0);
    chk("R10 irq after reset", {31'd0, irq}, 32'd0);
    wr(4'd4, 16'h0000); rd(4'd4, d); chk("R1 csr after zero write", {16'd0, d}, 32'h1400);

    // R2 vector
    wr(4'd7, 16'h0055); rd(4'd7, d); chk("R2 vector", {16'd0, d}, 32'h3D55);

    // R9 residual held clear while fifo reset low
    wr(4'd9, 16'h1234); rd(4'd9, d); chk("R9 residual held", {16'd0, d}, 32'd0);

    // R11 select and count halves
    wr(4'd4, 16'h0003); rd(4'd4, d); chk("R11 csr with select", {16'd0, d}, 32'h1403);
    chk("R11 select pin", {31'd0, scsi_sel}, 32'd1);
    wr(4'd2, 16'hABCD); rd(4'd2, d); chk("R11 count high", {16'd0, d}, 32'hABCD);
    wr(4'd2, 16'h0000);

    // R3/R4 receive of 10 bytes
    wr(4'd4, 16'h0002);
    wr(4'd0, 16'h0000); wr(4'd1, 16'h1000); wr(4'd3, 16'd10);
    exp_q.push_back({32'h1000, b[0], b[1], b[2], b[3]});
    exp_q.push_back({32'h1004, b[4], b[5], b[6], b[7]});
    wr(4'd4, 16'h0036);
    rd(4'd9, d); chk("R4 residual loaded", {16'd0, d}, 32'd10);
    for (int i = 0; i < 10; i++) byte_rx(b[i]);
    repeat (4) @(negedge clk);
    chk("R3 all words written", exp_q.size(), 32'd0);
    rd(4'd9, d); chk("R4 residual zero", {16'd0, d}, 32'd0);
    rd(4'd4, d); chk("R4 csr done, two left", {16'd0, d}, 32'h11B6);
    chk("R10 irq on completion", {31'd0, irq}, 32'd1);
    rd(4'd5, d); chk("R5 pack high two bytes", {16'd0, d}, {16'd0, b[8], b[9]});
    rd(4'd1, d); chk("R3 address advanced", {16'd0, d}, 32'h1008);
    byte_none("R4 no byte at zero residual");

    // R9 fifo reset clears flags
    wr(4'd4, 16'h0000); wr(4'd4, 16'h0002);
    rd(4'd4, d); chk("R9 csr after fifo reset", {16'd0, d}, 32'h1402);
    chk("R10 irq cleared", {31'd0, irq}, 32'd0);

    // R5 early stop with three leftover bytes
    wr(4'd1, 16'h2000); wr(4'd3, 16'd20);
    exp_q.push_back({32'h2000, b[0], b[1], b[2], b[3]});
    wr(4'd4, 16'h0032);
    for (int i = 0; i < 7; i++) byte_rx(b[i]);
    repeat (4) @(negedge clk);
    wr(4'd4, 16'h0022);
    byte_none("R5 strobe ignored after stop");
    rd(4'd9, d); chk("R5 residual frozen", {16'd0, d}, 32'd13);
    rd(4'd4, d); chk("R5 csr three left", {16'd0, d}, 32'h10E2);
    rd(4'd5, d); chk("R5 pack high", {16'd0, d}, {16'd0, b[4], b[5]});
    rd(4'd6, d); chk("R5 pack low", {16'd0, d}, {16'd0, b[6], 8'h00});

    // R12 pack enable needed
    wr(4'd4, 16'h0000); wr(4'd4, 16'h0002); wr(4'd3, 16'd4);
    wr(4'd4, 16'h0012);
    byte_none("R12 no byte without pack enable");
    rd(4'd9, d); chk("R12 residual untouched", {16'd0, d}, 32'd4);

    // R6 send of 6 bytes
    wr(4'd4, 16'h0000); wr(4'd4, 16'h0002);
    wr(4'd1, 16'h3000); wr(4'd3, 16'd6);
    wr(4'd4, 16'h003A);
    for (int i = 0; i < 6; i++) begin
      logic [31:0] w;
      w = mword(32'h3000 + 32'(4 * (i / 4)));
      byte_tx("R6 send byte", w[31 - 8 * (i % 4) -: 8]);
    end
    rd(4'd1, d); chk("R6 address after reads", {16'd0, d}, 32'h3008);
    rd(4'd9, d); chk("R6 residual zero", {16'd0, d}, 32'd0);
    byte_none("R6 no byte after last");

    // R7 bus error
    wr(4'd4, 16'h0000); wr(4'd4, 16'h0002);
    wr(4'd1, 16'h4000); wr(4'd3, 16'd8);
    err_arm = 1;
    wr(4'd4, 16'h0036);
    for (int i = 0; i < 4; i++) byte_rx(b[i]);
    repeat (4) @(negedge clk);
    err_arm = 0;
    rd(4'd4, d); chk("R7 bus error status", {16'd0, d}, 32'h3036);
    chk("R10 irq on bus error", {31'd0, irq}, 32'd1);
    byte_none("R7 transfer stopped");
    repeat (3) @(negedge clk);
    rd(4'd4, d); chk("R7 error sticky", {16'd0, d}, 32'h3036);
    wr(4'd4, 16'h0034);
    rd(4'd4, d); chk("R7 cleared by fifo reset", {16'd0, d}, 32'h1434);

    // R8 conflict
    wr(4'd4, 16'h0000); wr(4'd4, 16'h0002); wr(4'd3, 16'd8);
    wr(4'd4, 16'h0036);
    wr(4'd1, 16'h5000);
    rd(4'd4, d); chk("R8 conflict status", {16'd0, d}, 32'hD436);
    chk("R10 irq on conflict", {31'd0, irq}, 32'd1);

    // R10 bus controller interrupt
    wr(4'd4, 16'h0000); wr(4'd4, 16'h0006);
    sbc_irq = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 irq from bus controller", {31'd0, irq}, 32'd1);
    rd(4'd4, d); chk("R10 csr bit 9", {16'd0, d}, 32'h1606);
    sbc_irq = 1'b0;

    done = 1;
    summary();
    $finish;
  end
endmodule